// File: doc/BRIEF.md
# Serial Qui-Binary Decimal Adder

This block adds or subtracts two decimal fields of any length, one digit pair per clock, starting with the low-order digit. Each incoming character is a 7-bit code: a check bit, two zone bits and four numeric bits. The numeric bits of both operands are turned into a qui-binary digit. That digit is a binary bit worth 0 or 1 plus a one-hot quinary group worth 0, 2, 4, 6 or 8. The second operand can be swapped for its nines' complement by mirroring the quinary group and inverting the binary bit. The two digits are summed with a running carry, and the result goes back to character form with odd parity.

A caller pulses start with the operation select, then streams digit pairs under a valid/ready handshake. The pair that carries a word mark on either operand is the last one of the field. A done pulse and the final carry then end the run. In subtract mode the first carry-in is 1, so complement addition gives the true difference. The final carry is 1 when the minuend is not smaller than the subtrahend.

Top module: `qb_serial_adder`

## Requirements
- R1: After reset, ready_o, res_valid_o, done_o, invalid_o and carry_o are all 0.
- R2: A start_i pulse while idle raises ready_o on the next cycle and loads carry_o with sub_i, which is the carry into the low-order digit.
- R3: The value of a character is read from bits [3:0] (weights 8, 4, 2, 1). Nibble 0 and nibble 10 (bits 8 and 2) both mean zero, and nibbles 1 to 9 mean themselves. Nibbles 11 to 15 set invalid_o for that digit and count as zero. Bit 6 (check) of an input is not examined.
- R4: With sub_i = 0, each result digit is (a + b + carry) mod 10, and the carry into the next digit is 1 when that sum is 10 or more.
- R5: With sub_i = 1, operand b is replaced by 9 − b. Over a whole field the result is a − b modulo a power of ten, and the final carry is 1 exactly when a ≥ b.
- R6: The low four bits of a result character hold the digit, with zero written as nibble 10. Bits [5:4] are copied from operand a. Bit 6 is set so that all seven bits hold an odd number of ones.
- R7: The digit pair with a_wm_i or b_wm_i set is the last of the field. done_o pulses together with its result, ready_o falls on the same cycle, and carry_o then holds the field's final carry until the next start.
- R8: res_valid_o is high for exactly one cycle per accepted digit, on the cycle after acceptance. valid_i while ready_o is low yields no result.
- R9: start_i while a field is in progress is ignored: the operation and the running carry are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a field operation |
| sub_i | input | 1 | 1 selects complement of operand b (subtract), sampled with start_i |
| valid_i | input | 1 | A digit pair is present |
| ready_o | output | 1 | Block accepts a digit pair |
| a_char_i | input | 7 | Operand a character {C,B,A,8,4,2,1} |
| a_wm_i | input | 1 | Word mark on operand a character |
| b_char_i | input | 7 | Operand b character {C,B,A,8,4,2,1} |
| b_wm_i | input | 1 | Word mark on operand b character |
| res_char_o | output | 7 | Result character {C,B,A,8,4,2,1} |
| res_valid_o | output | 1 | Result character valid |
| invalid_o | output | 1 | An operand of this digit had an invalid numeric code |
| done_o | output | 1 | Last digit of the field is on the result port |
| carry_o | output | 1 | Running carry; final carry after done |

## Verification
A wrong quinary index or a swapped complement mapping shows up on res_char_o one cycle after the digit pair is accepted. A carry that is stored wrongly shows up one digit later, or on carry_o after done. Each result character is compared with a digit-level reference model. The bench feeds random fields mixed with directed carry chains, zero encodings, invalid codes, gaps in the handshake and a stray start. A broken field end appears as a missing or early done_o and a ready_o that does not fall.

// File: rtl/qb_pkg.sv
package qb_pkg;
  localparam int unsigned QW   = 5;   // quinary group Q0,Q2,Q4,Q6,Q8
  localparam int unsigned CW   = 7;   // character C,B,A,8,4,2,1
  localparam int unsigned NW   = 4;   // numeric field
  localparam int unsigned DW   = 4;   // decimal digit value
  localparam int unsigned SW   = DW + 1;
  localparam logic [NW-1:0] ZERO_CODE = 4'd10;

  typedef struct packed {
    logic [QW-1:0] q;
    logic          b;
  } qb_t;

  function automatic logic [2:0] q_index(input logic [QW-1:0] q);
    logic [2:0] idx;
    idx = '0;
    for (int i = 0; i < QW; i++) begin
      if (q[i]) idx = 3'(i);
    end
    return idx;
  endfunction

  function automatic logic [DW-1:0] qb_value(input qb_t d);
    return {q_index(d.q), d.b};
  endfunction
endpackage

// File: rtl/qb_decode.sv
module qb_decode
  import qb_pkg::*;
(
  input  logic [NW-1:0] num_i,
  output qb_t           dig_o,
  output logic          invalid_o
);
  logic [2:0] grp;

  always_comb begin
    grp       = num_i[3:1];
    invalid_o = (num_i > ZERO_CODE);
    dig_o     = '{q: 5'b00001, b: 1'b0};
    if (!invalid_o) begin
      // 8+2 is the character form of zero
      if (num_i == ZERO_CODE) dig_o = '{q: 5'b00001, b: 1'b0};
      else                    dig_o = '{q: QW'(1) << grp, b: num_i[0]};
    end
  end
endmodule

// File: rtl/qb_complement.sv
module qb_complement
  import qb_pkg::*;
(
  input  qb_t  dig_i,
  input  logic comp_i,
  output qb_t  dig_o
);
  qb_t mirrored;

  // 9 - (2k + b) = 2(4 - k) + (1 - b)
  always_comb begin
    for (int i = 0; i < QW; i++) mirrored.q[i] = dig_i.q[QW-1-i];
    mirrored.b = ~dig_i.b;
    dig_o = comp_i ? mirrored : dig_i;
  end
endmodule

// File: rtl/qb_digit_add.sv
module qb_digit_add
  import qb_pkg::*;
(
  input  qb_t  a_i,
  input  qb_t  b_i,
  input  logic cin_i,
  output qb_t  sum_o,
  output logic cout_o
);
  logic [SW-1:0] raw;
  logic [SW-1:0] red;

  always_comb begin
    raw    = SW'(qb_value(a_i)) + SW'(qb_value(b_i)) + SW'(cin_i);
    cout_o = (raw >= SW'(10));
    red    = cout_o ? raw - SW'(10) : raw;
    sum_o  = '{q: QW'(1) << red[3:1], b: red[0]};
  end
endmodule

// File: rtl/qb_encode.sv
module qb_encode
  import qb_pkg::*;
(
  input  qb_t        dig_i,
  input  logic [1:0] zone_i,
  output logic [CW-1:0] char_o
);
  logic [DW-1:0] val;
  logic [NW-1:0] num;

  always_comb begin
    val    = qb_value(dig_i);
    num    = (val == '0) ? ZERO_CODE : val;
    char_o = {~^{zone_i, num}, zone_i, num};
  end
endmodule

// File: rtl/qb_serial_adder.sv
module qb_serial_adder
  import qb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          sub_i,
  input  logic          valid_i,
  output logic          ready_o,
  input  logic [CW-1:0] a_char_i,
  input  logic          a_wm_i,
  input  logic [CW-1:0] b_char_i,
  input  logic          b_wm_i,
  output logic [CW-1:0] res_char_o,
  output logic          res_valid_o,
  output logic          invalid_o,
  output logic          done_o,
  output logic          carry_o
);
  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e        state_q;
  logic          sub_q, carry_q;
  logic          accept, last;
  qb_t           dig_a, dig_b_raw, dig_b, dig_s;
  logic          inv_a, inv_b, cout;
  logic [CW-1:0] res_c;
  logic [2:0]    unused_bits;

  assign unused_bits = {a_char_i[6], b_char_i[5:4]};

  qb_decode i_dec_a (.num_i(a_char_i[3:0]), .dig_o(dig_a),     .invalid_o(inv_a));
  qb_decode i_dec_b (.num_i(b_char_i[3:0]), .dig_o(dig_b_raw), .invalid_o(inv_b));
  qb_complement i_comp (.dig_i(dig_b_raw), .comp_i(sub_q), .dig_o(dig_b));
  qb_digit_add i_add (.a_i(dig_a), .b_i(dig_b), .cin_i(carry_q), .sum_o(dig_s), .cout_o(cout));
  qb_encode i_enc (.dig_i(dig_s), .zone_i(a_char_i[5:4]), .char_o(res_c));

  assign ready_o = (state_q == ST_RUN);
  assign accept  = ready_o && valid_i;
  assign last    = a_wm_i || b_wm_i;
  assign carry_o = carry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sub_q       <= 1'b0;
      carry_q     <= 1'b0;
      res_char_o  <= '0;
      res_valid_o <= 1'b0;
      invalid_o   <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      res_valid_o <= accept;
      done_o      <= accept && last;
      invalid_o   <= accept && (inv_a || inv_b);
      if (accept) res_char_o <= res_c;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          sub_q   <= sub_i;
          carry_q <= sub_i;
        end
        ST_RUN: if (accept) begin
          carry_q <= cout;
          if (last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> !res_valid_o || $past(ready_o));
  a_r3_onehot_digits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> ($onehot(dig_a.q) && $onehot(dig_b.q) && $onehot(dig_s.q)));
  a_r4_digit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_char_o[3:0] >= 4'd1 && res_char_o[3:0] <= 4'd10));
  a_r6_odd_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ($countones(res_char_o) % 2 == 1));
  a_r7_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (res_valid_o && !ready_o));
  a_r8_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> res_valid_o);
  a_r8_no_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !res_valid_o);
  a_r9_sub_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |-> $stable(sub_q));
endmodule

// File: tb/test_qb_serial_adder.sv
`timescale 1ns/1ps
module test_qb_serial_adder;
  logic clk = 0, rst_n = 0;
  logic start_i = 0, sub_i = 0, valid_i = 0, a_wm_i = 0, b_wm_i = 0;
  logic [6:0] a_char_i = 0, b_char_i = 0;
  logic ready_o, res_valid_o, invalid_o, done_o, carry_o;
  logic [6:0] res_char_o;
  int n_run = 0, n_fail = 0;
  logic [6:0] fa[8], fb[8];

  always #10 clk = ~clk;

  qb_serial_adder i_qb_serial_adder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .sub_i(sub_i),
    .valid_i(valid_i), .ready_o(ready_o), .a_char_i(a_char_i), .a_wm_i(a_wm_i),
    .b_char_i(b_char_i), .b_wm_i(b_wm_i), .res_char_o(res_char_o),
    .res_valid_o(res_valid_o), .invalid_o(invalid_o), .done_o(done_o),
    .carry_o(carry_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int val_of(input logic [6:0] c);
    if (c[3:0] == 4'd10 || c[3:0] == 4'd0) return 0;
    if (c[3:0] <= 4'd9) return int'(c[3:0]);
    return 0;
  endfunction

  function automatic logic [6:0] mk_char(input int d, input logic [1:0] z);
    logic [3:0] n;
    n = (d == 0) ? 4'd10 : 4'(d);
    return {~^{z, n}, z, n};
  endfunction

  function automatic logic [6:0] rnd_char();
    logic [6:0] c;
    if ($urandom_range(0, 7) == 0) begin
      c = 7'($urandom);
      c[3:0] = 4'($urandom_range(11, 15));
    end else begin
      c = mk_char(int'($urandom_range(0, 9)), 2'($urandom));
      if ($urandom_range(0, 3) == 0) c[3:0] = 4'd0;
      if ($urandom_range(0, 3) == 0) c[6] = ~c[6];
    end
    return c;
  endfunction

  task automatic run_field(input int n, input bit sub, input bit gap,
                           input bit mid_start, input bit use_bwm);
    int cin, s, vb;
    logic [6:0] e;
    bit inv;
    @(negedge clk);
    start_i = 1; sub_i = sub;
    @(negedge clk);
    start_i = 0;
    chk(ready_o == 1, "R2", "ready after start", ready_o, 1);
    chk(carry_o == sub, "R2", "initial carry", carry_o, sub);
    cin = sub;
    for (int i = 0; i < n; i++) begin
      a_char_i = fa[i]; b_char_i = fb[i];
      a_wm_i = (i == n-1) && !use_bwm;
      b_wm_i = (i == n-1) && use_bwm;
      valid_i = 1;
      if (mid_start && i == 1) begin start_i = 1; sub_i = ~sub; end
      vb  = val_of(fb[i]);
      if (sub) vb = 9 - vb;
      s   = val_of(fa[i]) + vb + cin;
      cin = (s >= 10) ? 1 : 0;
      e   = mk_char(s % 10, fa[i][5:4]);
      inv = (fa[i][3:0] > 4'd10) || (fb[i][3:0] > 4'd10);
      @(negedge clk);
      start_i = 0;
      chk(res_valid_o == 1, "R8", "result valid", res_valid_o, 1);
      chk(res_char_o == e, sub ? (mid_start ? "R9" : "R5") : "R4",
          "result char", res_char_o, e);
      chk(invalid_o == inv, "R3", "invalid flag", invalid_o, inv);
      chk(done_o == (i == n-1), "R7", "done", done_o, (i == n-1));
      if (gap && i == 0 && n > 1) begin
        valid_i = 0;
        @(negedge clk);
        chk(res_valid_o == 0, "R8", "no result in gap", res_valid_o, 0);
      end
    end
    valid_i = 0; a_wm_i = 0; b_wm_i = 0;
    chk(ready_o == 0, "R7", "ready falls at done", ready_o, 0);
    @(negedge clk);
    chk(carry_o == cin, "R7", "final carry", carry_o, cin);
    chk(res_valid_o == 0 && done_o == 0, "R8", "quiet after field",
        {res_valid_o, done_o}, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4821));
    repeat (3) @(negedge clk);
    chk({ready_o, res_valid_o, done_o, invalid_o, carry_o} == 0, "R1",
        "reset outputs", {ready_o, res_valid_o, done_o, invalid_o, carry_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(ready_o == 0, "R1", "idle ready", ready_o, 0);
    // valid while idle is ignored
    valid_i = 1; a_wm_i = 1; a_char_i = mk_char(5, 0); b_char_i = mk_char(5, 0);
    @(negedge clk);
    chk(res_valid_o == 0 && done_o == 0, "R8", "idle valid ignored",
        {res_valid_o, done_o}, 0);
    valid_i = 0; a_wm_i = 0;
    // 999 + 001: carry chain, zero encoding
    fa[0] = mk_char(9,0); fa[1] = mk_char(9,0); fa[2] = mk_char(9,2'b11);
    fb[0] = mk_char(1,0); fb[1] = mk_char(0,0); fb[2] = mk_char(0,0);
    run_field(3, 0, 0, 0, 0);
    // 5 - 7 single digit, no carry out
    fa[0] = mk_char(5,2'b01); fb[0] = mk_char(7,0);
    run_field(1, 1, 0, 0, 0);
    // 0 - 0: carry out, blank numeric counts as zero
    fa[0] = 7'b1000000; fb[0] = mk_char(0,0);
    run_field(1, 1, 0, 0, 1);
    // invalid code, gap in handshake, word mark on b
    fa[0] = mk_char(3,0); fa[1] = 7'b0001011; fa[2] = mk_char(4,2'b10);
    fb[0] = 7'b0001111; fb[1] = mk_char(2,0); fb[2] = mk_char(8,0);
    run_field(3, 0, 1, 0, 1);
    // start during field is ignored
    fa[0] = mk_char(2,0); fa[1] = mk_char(6,0); fa[2] = mk_char(1,0);
    fb[0] = mk_char(8,0); fb[1] = mk_char(3,0); fb[2] = mk_char(0,0);
    run_field(3, 1, 0, 1, 0);
    for (int k = 0; k < 300; k++) begin
      int n;
      n = int'($urandom_range(1, 8));
      for (int i = 0; i < n; i++) begin fa[i] = rnd_char(); fb[i] = rnd_char(); end
      run_field(n, 1'($urandom), ($urandom_range(0, 4) == 0), 0,
                1'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule